// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Engine

This is a datapath for fixed-point signal processing. Each issued operation takes two 16-bit operands. It forms their product through a 17x17 signed multiplier and writes the result into one of two 40-bit accumulators. The result is the product itself, its negation, the product added to or subtracted from the accumulator, a square, or the square of the operand difference. Each operand is widened by one bit, by sign or by zero, so signed, unsigned and mixed-sign products all come out exact. Fractional mode doubles the product, which turns the 1.15 x 1.15 case (-1.0)x(-1.0) into a positive +1.0. It does not wrap.

Control inputs select fractional or integer mode, the signedness of each operand, and automatic saturation for each accumulator. Saturation clamps either at 1.31 (bit 31) or at the full 40-bit range. Each accumulator keeps two sticky overflow flags, one for each of these boundaries. A separate combinational store path rounds bits 31:16 of a chosen accumulator, using either conventional or round-to-even rounding, and can clamp the result to 16 bits.

Top module: `mac_engine`

## Requirements
- R1: While rst_n is low, both accumulators and all four overflow flags are zero. store_out therefore reads 0x0000.
- R2: Operand x is extended to 17 bits by sign when x_signed=1 and by zero otherwise; y is extended the same way by y_signed. In integer mode (frac_mode=0) the 34-bit product is sign-extended to 40 bits.
- R3: In fractional mode (frac_mode=1) the product is shifted left by one bit before sign extension. Signed 0x8000 x 0x8000 therefore gives 0x0080000000.
- R4: On a clock edge with op_valid=1, the accumulator chosen by acc_sel (0=A, 1=B) takes the result of op_code. The codes are: 0 clear, 1 product, 2 negated product, 3 acc+product, 4 acc-product, 5 x*x, 6 acc+x*x, 7 (x-y)^2, 8 acc+(x-y)^2. The other accumulator keeps its value.
- R5: For codes 7 and 8 the difference x-y is taken modulo 2^16 and extended by the x_signed rule before it is squared.
- R6: When op_valid=0, or when op_code is 9 to 15, neither accumulator nor any flag changes.
- R7: When saturation is enabled for the target (sat_en_a or sat_en_b) and sat_wide=0, a result outside the signed 32-bit range is clamped to 0x007FFFFFFF or 0xFF80000000.
- R8: When saturation is enabled and sat_wide=1, a result outside the signed 40-bit range is clamped to 0x7FFFFFFFFF or 0x8000000000.
- R9: When saturation is disabled for the target, the accumulator takes the low 40 bits of the exact result.
- R10: The narrow flag of an accumulator sets when an exact result leaves the signed 32-bit range. The wide flag sets when it leaves the signed 40-bit range. Both flags set whether saturation is enabled or not, stay set, and clear only on reset or on a clear (code 0) to that accumulator.
- R11: With conv_round=0, store_out is bits 31:16 of the accumulator plus 0x8000.
- R12: With conv_round=1, when the low 16 bits are exactly 0x8000, 0x8000 is added only if bit 16 is 1, so that bit 16 of the result is 0. All other values round as in R11.
- R13: With sat_store=1, a rounded value outside the signed 32-bit range gives store_out 0x7FFF (positive) or 0x8000 (negative).
- R14: store_out follows the register chosen by store_sel without delay. In the issue cycle of an operation on that accumulator it still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issue strobe for an operation |
| op_code | input | 4 | Operation code |
| acc_sel | input | 1 | Target accumulator, 0=A 1=B |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| frac_mode | input | 1 | 1 = fractional, 0 = integer |
| x_signed | input | 1 | x is signed |
| y_signed | input | 1 | y is signed |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_wide | input | 1 | 1 = clamp at 40 bits, 0 = at 32 bits |
| store_sel | input | 1 | Accumulator read by the store path |
| conv_round | input | 1 | 1 = round to even on a tie |
| sat_store | input | 1 | Store path saturation enable |
| store_out | output | 16 | Rounded store word |
| acc_a_out | output | 40 | Accumulator A |
| acc_b_out | output | 40 | Accumulator B |
| narrow_ovf_a | output | 1 | Sticky 32-bit overflow, A |
| wide_ovf_a | output | 1 | Sticky 40-bit overflow, A |
| narrow_ovf_b | output | 1 | Sticky 32-bit overflow, B |
| wide_ovf_b | output | 1 | Sticky 40-bit overflow, B |

## Verification
Two functions can meet in one cycle: a read through the store path and a write into the same accumulator. The bench aims the store selector at the target accumulator of every issued operation. While the strobe is high and before the edge, it checks that the rounded word still reflects the old contents. After the edge it checks all four rounding and saturation combinations against the new value. Sweeps and directed runs also drive saturation and flag setting in one operation, and the bench judges the clamped value and the flag together.

// File: rtl/mac_engine.sv
module mac_engine #(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      op_code,
  input  logic            acc_sel,
  input  logic [OPW-1:0]  x_in,
  input  logic [OPW-1:0]  y_in,
  input  logic            frac_mode,
  input  logic            x_signed,
  input  logic            y_signed,
  input  logic            sat_en_a,
  input  logic            sat_en_b,
  input  logic            sat_wide,
  input  logic            store_sel,
  input  logic            conv_round,
  input  logic            sat_store,
  output logic [OPW-1:0]  store_out,
  output logic [ACCW-1:0] acc_a_out,
  output logic [ACCW-1:0] acc_b_out,
  output logic            narrow_ovf_a,
  output logic            wide_ovf_a,
  output logic            narrow_ovf_b,
  output logic            wide_ovf_b
);
  localparam int MW     = OPW + 1;
  localparam int PW     = 2 * MW;
  localparam int NARROW = 2 * OPW;
  localparam int TOPW   = ACCW - NARROW + 2;
  localparam logic [ACCW-1:0] NMAX = {{(ACCW-NARROW+1){1'b0}}, {(NARROW-1){1'b1}}};
  localparam logic [ACCW-1:0] NMIN = ~NMAX;
  localparam logic [ACCW-1:0] WMAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] WMIN = ~WMAX;
  localparam logic [ACCW:0]   HALF = (ACCW+1)'(1) << (OPW-1);
  localparam logic [OPW-1:0]  SMAX = {1'b0, {(OPW-1){1'b1}}};

  typedef enum logic [3:0] {
    OP_CLR = 4'd0, OP_MPY = 4'd1, OP_MPYN = 4'd2, OP_MAC = 4'd3, OP_MSC = 4'd4,
    OP_SQR = 4'd5, OP_SQRAC = 4'd6, OP_ED = 4'd7, OP_EDAC = 4'd8
  } op_e;

  logic [ACCW-1:0] acc_q [2];
  logic            ovn_q [2];
  logic            ovw_q [2];

  // operand extension and 17x17 multiply
  logic [OPW-1:0]         dif;
  logic signed [MW-1:0]   xe, ye, de, ma, mb;
  logic signed [PW-1:0]   prod;
  logic [ACCW-1:0]        pext;

  assign dif = x_in - y_in;
  assign xe  = {x_signed & x_in[OPW-1], x_in};
  assign ye  = {y_signed & y_in[OPW-1], y_in};
  assign de  = {x_signed & dif[OPW-1], dif};

  always_comb begin
    case (op_code)
      OP_SQR, OP_SQRAC: begin ma = xe; mb = xe; end
      OP_ED, OP_EDAC:   begin ma = de; mb = de; end
      default:          begin ma = xe; mb = ye; end
    endcase
  end

  assign prod = ma * mb;
  assign pext = frac_mode ? {{(ACCW-PW-1){prod[PW-1]}}, prod, 1'b0}
                          : {{(ACCW-PW){prod[PW-1]}}, prod};

  // operation decode
  logic code_ok, use_acc, negate, is_clr;
  always_comb begin
    code_ok = 1'b1; use_acc = 1'b0; negate = 1'b0; is_clr = 1'b0;
    case (op_code)
      OP_CLR:                    is_clr  = 1'b1;
      OP_MPY, OP_SQR, OP_ED:     ;
      OP_MPYN:                   negate  = 1'b1;
      OP_MAC, OP_SQRAC, OP_EDAC: use_acc = 1'b1;
      OP_MSC:                    begin use_acc = 1'b1; negate = 1'b1; end
      default:                   code_ok = 1'b0;
    endcase
  end

  // 41-bit exact add/subtract
  logic [ACCW-1:0] cur;
  logic [ACCW:0]   base, padd, sum;
  logic [TOPW-1:0] top;
  logic            ovn, ovw, sat_on;
  logic [ACCW-1:0] res;

  assign cur  = acc_sel ? acc_q[1] : acc_q[0];
  assign base = use_acc ? {cur[ACCW-1], cur} : '0;
  assign padd = {pext[ACCW-1], pext};
  assign sum  = is_clr ? '0 : (negate ? base - padd : base + padd);
  assign top  = sum[ACCW:NARROW-1];
  assign ovn  = !((&top) || !(|top));
  assign ovw  = sum[ACCW] ^ sum[ACCW-1];
  assign sat_on = acc_sel ? sat_en_b : sat_en_a;

  always_comb begin
    res = sum[ACCW-1:0];
    if (sat_on) begin
      if (sat_wide) begin
        if (ovw) res = sum[ACCW] ? WMIN : WMAX;
      end else if (ovn) begin
        res = sum[ACCW] ? NMIN : NMAX;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        acc_q[i] <= '0;
        ovn_q[i] <= 1'b0;
        ovw_q[i] <= 1'b0;
      end
    end else if (op_valid && code_ok) begin
      for (int i = 0; i < 2; i++) begin
        if (acc_sel == i[0]) begin
          acc_q[i] <= res;
          ovn_q[i] <= !is_clr && (ovn_q[i] || ovn);
          ovw_q[i] <= !is_clr && (ovw_q[i] || ovw);
        end
      end
    end
  end

  assign acc_a_out    = acc_q[0];
  assign acc_b_out    = acc_q[1];
  assign narrow_ovf_a = ovn_q[0];
  assign wide_ovf_a   = ovw_q[0];
  assign narrow_ovf_b = ovn_q[1];
  assign wide_ovf_b   = ovw_q[1];

  // store path: round, then optional 16-bit clamp
  logic [ACCW-1:0] sacc;
  logic [ACCW:0]   rs;
  logic [TOPW-1:0] stop;
  logic            tie, add_half, sov;

  assign sacc     = store_sel ? acc_q[1] : acc_q[0];
  assign tie      = sacc[OPW-1:0] == HALF[OPW-1:0];
  assign add_half = !(conv_round && tie && !sacc[OPW]);
  assign rs       = {sacc[ACCW-1], sacc} + (add_half ? HALF : '0);
  assign stop     = rs[ACCW:NARROW-1];
  assign sov      = !((&stop) || !(|stop));
  assign store_out = (sat_store && sov) ? (rs[ACCW] ? ~SMAX : SMAX) : rs[NARROW-1:OPW];

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_a_out) && $stable(acc_b_out)));

  // R4
  other_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !acc_sel) |=> $stable(acc_b_out));

  // R4
  clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && acc_sel && op_code == OP_CLR) |=> (acc_b_out == '0 && !wide_ovf_b && !narrow_ovf_b));

  // R7
  narrow_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && code_ok && !acc_sel && sat_en_a && !sat_wide)
      |=> ((&acc_a_out[ACCW-1:NARROW-1]) || !(|acc_a_out[ACCW-1:NARROW-1])));

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_ovf_a && !(op_valid && !acc_sel && op_code == OP_CLR)) |=> narrow_ovf_a);

  // R10
  flag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wide_ovf_b |-> narrow_ovf_b);
endmodule

// File: tb/sim_mac_engine.sv
`timescale 1ns/1ps
module sim_mac_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic acc_sel = 1'b0;
  logic [15:0] x_in = '0, y_in = '0;
  logic frac_mode = 0, x_signed = 0, y_signed = 0, sat_en_a = 0, sat_en_b = 0, sat_wide = 0;
  logic store_sel = 0, conv_round = 0, sat_store = 0;
  logic [15:0] store_out;
  logic [39:0] acc_a_out, acc_b_out;
  logic narrow_ovf_a, wide_ovf_a, narrow_ovf_b, wide_ovf_b;

  always #2.5 clk = ~clk;

  mac_engine u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [39:0] m_acc [2];
  bit m_n [2], m_w [2];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint ext(input logic [15:0] v, input bit s);
    return s ? {{48{v[15]}}, v} : {48'b0, v};
  endfunction

  function automatic logic [15:0] st_model(input logic [39:0] a, input bit conv, input bit sat);
    longint v, r;
    v = {{24{a[39]}}, a};
    r = (conv && a[15:0] == 16'h8000 && !a[16]) ? v : v + 32768;
    if (sat && r > 64'sh7FFFFFFF) return 16'h7FFF;
    if (sat && r < -64'sh80000000) return 16'h8000;
    return r[31:16];
  endfunction

  task automatic model_op(input logic [3:0] op, input bit sel, input logic [5:0] c,
                          input logic [15:0] x, input logic [15:0] y);
    longint p, cur, t, lim;
    logic [15:0] d;
    bit sat, ovn, ovw;
    if (op > 8) return;
    d = x - y;
    if (op == 5 || op == 6) p = ext(x, c[4]) * ext(x, c[4]);
    else if (op == 7 || op == 8) p = ext(d, c[4]) * ext(d, c[4]);
    else p = ext(x, c[4]) * ext(y, c[3]);
    if (c[5]) p = p * 2;
    cur = {{24{m_acc[sel][39]}}, m_acc[sel]};
    case (op)
      0: t = 0;
      1, 5, 7: t = p;
      2: t = -p;
      3, 6, 8: t = cur + p;
      default: t = cur - p;
    endcase
    ovn = t > 64'sh7FFFFFFF || t < -64'sh80000000;
    ovw = t > 64'sh7FFFFFFFFF || t < -64'sh8000000000;
    sat = sel ? c[1] : c[2];
    if (sat && c[0] && ovw) t = (t < 0) ? -64'sh8000000000 : 64'sh7FFFFFFFFF;
    if (sat && !c[0] && ovn) t = (t < 0) ? -64'sh80000000 : 64'sh7FFFFFFF;
    m_acc[sel] = t[39:0];
    lim = 0;
    if (op == 0) begin m_n[sel] = 0; m_w[sel] = 0; end
    else begin m_n[sel] = m_n[sel] | ovn; m_w[sel] = m_w[sel] | ovw; end
  endtask

  task automatic do_op(input logic [3:0] op, input bit sel, input logic [5:0] c,
                       input logic [15:0] x, input logic [15:0] y);
    logic [39:0] old;
    @(negedge clk);
    op_code = op; acc_sel = sel; x_in = x; y_in = y;
    {frac_mode, x_signed, y_signed, sat_en_a, sat_en_b, sat_wide} = c;
    store_sel = sel; conv_round = 0; sat_store = 0; op_valid = 1;
    old = m_acc[sel];
    #0.5;
    chk(store_out == st_model(old, 0, 0), "R14", "store in issue cycle", store_out, st_model(old, 0, 0));
    model_op(op, sel, c, x, y);
    @(negedge clk);
    op_valid = 0;
    chk(acc_a_out == m_acc[0], "R4", "acc A", acc_a_out, m_acc[0]);
    chk(acc_b_out == m_acc[1], "R4", "acc B", acc_b_out, m_acc[1]);
    chk({narrow_ovf_a, wide_ovf_a, narrow_ovf_b, wide_ovf_b} == {m_n[0], m_w[0], m_n[1], m_w[1]},
        "R10", "flags", {narrow_ovf_a, wide_ovf_a, narrow_ovf_b, wide_ovf_b}, {m_n[0], m_w[0], m_n[1], m_w[1]});
    for (int k = 0; k < 4; k++) begin
      {conv_round, sat_store} = k[1:0];
      #0.4;
      chk(store_out == st_model(m_acc[sel], k[1], k[0]), "R13", "store round/sat",
          store_out, st_model(m_acc[sel], k[1], k[0]));
    end
    conv_round = 0; sat_store = 0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {op, sel, ctl{frac,xs,ys,sata,satb,wide}, x, y, expected target accumulator}
  localparam logic [82:0] VEC [12] = '{
    {4'd1, 1'b0, 6'b011000, 16'h0003, 16'h0004, 40'h000000000C},
    {4'd3, 1'b0, 6'b011000, 16'h0002, 16'h0005, 40'h0000000016},
    {4'd4, 1'b0, 6'b011000, 16'h000A, 16'h000A, 40'hFFFFFFFFB2},
    {4'd2, 1'b0, 6'b011000, 16'hFFFF, 16'h0007, 40'h0000000007},
    {4'd6, 1'b0, 6'b011000, 16'h0003, 16'h0000, 40'h0000000010},
    {4'd8, 1'b0, 6'b011000, 16'h0001, 16'h0004, 40'h0000000019},
    {4'd5, 1'b0, 6'b011000, 16'hFFFE, 16'h0000, 40'h0000000004},
    {4'd7, 1'b0, 6'b011000, 16'h8000, 16'h7FFF, 40'h0000000001},
    {4'd3, 1'b1, 6'b011000, 16'h8000, 16'h8000, 40'h0040000000},
    {4'd0, 1'b0, 6'b011000, 16'h1234, 16'h5678, 40'h0000000000},
    {4'd4, 1'b1, 6'b011000, 16'h0001, 16'h0001, 40'h003FFFFFFF},
    {4'd8, 1'b1, 6'b011000, 16'h0000, 16'h8000, 40'h007FFFFFFF}
  };

  initial begin
    #(5.0 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] corner [3];
    corner[0] = 16'h8000; corner[1] = 16'h7FFF; corner[2] = 16'hFFFF;
    for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_n[i] = 0; m_w[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(acc_a_out == 0 && acc_b_out == 0, "R1", "accs in reset", acc_a_out | acc_b_out, 0);
    chk({narrow_ovf_a, wide_ovf_a, narrow_ovf_b, wide_ovf_b} == 0, "R1", "flags in reset",
        {narrow_ovf_a, wide_ovf_a, narrow_ovf_b, wide_ovf_b}, 0);
    chk(store_out == 0, "R1", "store in reset", store_out, 0);
    rst_n = 1;

    // vector table: R4 and R5 with hand-computed results
    for (int v = 0; v < 12; v++) begin
      do_op(VEC[v][82:79], VEC[v][78], VEC[v][77:72], VEC[v][71:56], VEC[v][55:40]);
      chk((VEC[v][78] ? acc_b_out : acc_a_out) == VEC[v][39:0], "R5", "table vector",
          VEC[v][78] ? acc_b_out : acc_a_out, VEC[v][39:0]);
    end

    // R3 fractional (-1.0)x(-1.0)
    do_op(4'd1, 0, 6'b111000, 16'h8000, 16'h8000);
    chk(acc_a_out == 40'h0080000000, "R3", "frac -1*-1", acc_a_out, 40'h0080000000);
    // R2 signedness
    do_op(4'd1, 0, 6'b000000, 16'hFFFF, 16'hFFFF);
    chk(acc_a_out == 40'h00FFFE0001, "R2", "unsigned int", acc_a_out, 40'h00FFFE0001);
    do_op(4'd1, 0, 6'b010000, 16'hFFFF, 16'hFFFF);
    chk(acc_a_out == 40'hFFFFFF0001, "R2", "mixed sign", acc_a_out, 40'hFFFFFF0001);
    do_op(4'd1, 1, 6'b100000, 16'hFFFF, 16'hFFFF);
    chk(acc_b_out == 40'h01FFFC0002 && narrow_ovf_b, "R2", "unsigned frac", acc_b_out, 40'h01FFFC0002);
    // R6 unused code
    do_op(4'd9, 1, 6'b000000, 16'h1111, 16'h2222);
    chk(acc_b_out == 40'h01FFFC0002, "R6", "unused code", acc_b_out, 40'h01FFFC0002);
    @(negedge clk); op_code = 4'd3; acc_sel = 1; op_valid = 0;
    @(negedge clk);
    chk(acc_b_out == 40'h01FFFC0002, "R6", "no strobe", acc_b_out, 40'h01FFFC0002);

    // R7 narrow saturation and store clamp R13
    do_op(4'd1, 0, 6'b111100, 16'h8000, 16'h8000);
    chk(acc_a_out == 40'h007FFFFFFF && narrow_ovf_a, "R7", "narrow clamp", acc_a_out, 40'h007FFFFFFF);
    store_sel = 0; sat_store = 1; #0.3;
    chk(store_out == 16'h7FFF, "R13", "store clamp", store_out, 16'h7FFF);
    sat_store = 0; #0.3;
    chk(store_out == 16'h8000, "R11", "store no clamp", store_out, 16'h8000);

    // R8 wide saturation
    do_op(4'd0, 0, 6'b100101, 0, 0);
    chk(!narrow_ovf_a && !wide_ovf_a, "R10", "clear resets flags", narrow_ovf_a, 0);
    for (int i = 0; i < 70; i++) do_op(4'd3, 0, 6'b100101, 16'hFFFF, 16'hFFFF);
    chk(acc_a_out == 40'h7FFFFFFFFF && wide_ovf_a, "R8", "wide clamp", acc_a_out, 40'h7FFFFFFFFF);
    // R9 wrap without saturation
    do_op(4'd0, 1, 6'b100001, 0, 0);
    for (int i = 0; i < 70; i++) do_op(4'd3, 1, 6'b100001, 16'hFFFF, 16'hFFFF);
    chk(acc_b_out == 40'h8BFEE8008C && wide_ovf_b, "R9", "wrap", acc_b_out, 40'h8BFEE8008C);

    // R11 / R12 rounding ties
    do_op(4'd1, 0, 6'b000000, 16'h0001, 16'h8000);
    store_sel = 0; conv_round = 0; #0.3;
    chk(store_out == 16'h0001, "R11", "tie conventional", store_out, 1);
    conv_round = 1; #0.3;
    chk(store_out == 16'h0000, "R12", "tie to even down", store_out, 0);
    do_op(4'd1, 0, 6'b000000, 16'h0003, 16'h8000);
    conv_round = 1; #0.3;
    chk(store_out == 16'h0002, "R12", "tie to even up", store_out, 2);
    conv_round = 0;

    // sweep of every op and mode against the model
    for (int op = 0; op < 9; op++)
      for (int c = 0; c < 64; c++)
        for (int pr = 0; pr < 9; pr++)
          do_op(op[3:0], pr[0], c[5:0], corner[pr % 3], corner[pr / 3]);

    summary();
  end
endmodule